// File: doc/BRIEF.md
# History-Table Metric Predictor with Voting Update

This block forecasts the quantized value a performance metric (for example an IPC bucket or a cache miss-rate bucket) will take in the next measurement interval. At the end of every interval the surrounding logic presents one measured, already quantized value with a single-cycle strobe. The block keeps the four most recent measurements, folds them into an index, and looks up a table whose entries each carry a stored prediction and a stored "vote" (the value actually measured the last time that same history was seen). The looked-up prediction drives the output until the next strobe.

A table entry is not simply overwritten when a new measurement arrives. Instead its prediction becomes the majority of the stored vote, the stored prediction and the new measurement, so a single noisy interval cannot flip a prediction that two consistent observations agree on. Until four measurements have been seen, or while the indexed entry has never been written, the block raises its learning flag and repeats the most recent measurement. A parameter selects how the history is encoded into the index: a fixed-size hash of the four values, or a run-length view (current value, length of its run, and the value before the run).

The measurement input is a valid-only stream: there is no ready, the block takes a value on every cycle its strobe is high and never applies back-pressure. The prediction and learning outputs are plain status levels that change only on the clock edge that takes a measurement.

Top module: `metric_vote_predictor`

## Requirements
- R1: After reset the learning flag is 1, the prediction is 0, the history is empty and every table entry is invalid.
- R2: While fewer than four measurements have been taken since reset, the learning flag is 1 and the prediction equals the most recent measured value; no table entry is written by those measurements.
- R3: With the fixed-size encoding (ENC_SEL = 0), and h0 the newest of the four stored values through h3 the oldest, the 8-bit index is {h1 ^ rot(h3), h0 ^ rot(h2)}, where rot swaps the upper and lower 2-bit halves of a 4-bit value.
- R4: With the run-length encoding (ENC_SEL = 1), the index is {h0, p[3:2] ^ p[1:0], run-1}, where run (1 to 4) counts how many of h0, h1, h2, h3 in that order equal h0 before the first difference, and p is the first differing value (h0 itself when all four are equal).
- R5: When the indexed entry is invalid and four values are held, the learning flag is 1 and the prediction is the most recent measured value; a measurement taken in that state makes the entry valid with both its prediction and its vote equal to the measured value.
- R6: A measurement taken while the indexed entry is valid sets the entry's prediction to the majority of the stored vote, the stored prediction and the measured value; when all three differ, the measured value wins.
- R7: After every table write the entry's vote equals the measured value of that write.
- R8: On a cycle without a strobe the history, table, prediction and learning flag do not change.
- R9: When four values are held and the indexed entry is valid, the learning flag is 0 and the prediction is that entry's stored prediction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_valid | input | 1 | Strobe: a measurement is presented this cycle |
| meas_value | input | VAL_W | Quantized measured metric value |
| pred_value | output | VAL_W | Prediction for the coming interval |
| learning | output | 1 | 1 while the output is the last-value fallback |

## Verification
The bench builds two instances side by side with the default 4-bit values and 256-entry table, one with ENC_SEL = 0 and one with ENC_SEL = 1, so both index encodings see the same measurement stream. Periodic sequences make histories recur and bring the voting update into reach, including the case where the stored vote and prediction agree and resist a single outlier, and the case where all three voters differ. Idle gaps between strobes, constant runs that saturate the run length, and random noise reach the no-strobe hold, the invalid-entry fallback and collisions in the hashed index.

// File: rtl/mvp_pkg.sv
package mvp_pkg;
  localparam int HIST_LEN = 4;
  typedef enum logic {ENC_FIXED = 1'b0, ENC_RUNLEN = 1'b1} enc_e;
endpackage

// File: rtl/mvp_history.sv
module mvp_history #(
  parameter int VAL_W = 4
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        push,
  input  logic [VAL_W-1:0]                            value,
  output logic [mvp_pkg::HIST_LEN-1:0][VAL_W-1:0]     hist,
  output logic                                        full
);
  import mvp_pkg::*;
  localparam int CNT_W = $clog2(HIST_LEN + 1);

  logic [HIST_LEN-1:0][VAL_W-1:0] hist_q;
  logic [CNT_W-1:0]               fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (push) begin
      hist_q[0] <= value;
      for (int i = 1; i < HIST_LEN; i++) hist_q[i] <= hist_q[i-1];
      if (fill_q != CNT_W'(HIST_LEN)) fill_q <= fill_q + 1'b1;
    end
  end

  assign hist = hist_q;
  assign full = (fill_q == CNT_W'(HIST_LEN));

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(HIST_LEN));
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(hist_q) && $stable(fill_q));
endmodule

// File: rtl/mvp_index.sv
module mvp_index #(
  parameter int VAL_W   = 4,
  parameter int ENC_SEL = 0
) (
  input  logic [mvp_pkg::HIST_LEN-1:0][VAL_W-1:0] hist,
  output logic [2*VAL_W-1:0]                      idx
);
  import mvp_pkg::*;
  localparam int HALF = VAL_W / 2;

  generate
    if (ENC_SEL == int'(ENC_FIXED)) begin : g_fixed
      logic [VAL_W-1:0] rot2, rot3;
      assign rot2 = {hist[2][HALF-1:0], hist[2][VAL_W-1:HALF]};
      assign rot3 = {hist[3][HALF-1:0], hist[3][VAL_W-1:HALF]};
      assign idx  = {hist[1] ^ rot3, hist[0] ^ rot2};
    end else begin : g_runlen
      logic [HALF-1:0]  run_m1;
      logic [VAL_W-1:0] prev;
      logic             broke;
      always_comb begin
        run_m1 = '0;
        prev   = hist[0];
        broke  = 1'b0;
        for (int i = 1; i < HIST_LEN; i++) begin
          if (!broke) begin
            if (hist[i] == hist[0]) run_m1 = run_m1 + 1'b1;
            else begin
              broke = 1'b1;
              prev  = hist[i];
            end
          end
        end
      end
      assign idx = {hist[0], prev[VAL_W-1:HALF] ^ prev[HALF-1:0], run_m1};
    end
  endgenerate
endmodule

// File: rtl/mvp_table.sv
module mvp_table #(
  parameter int VAL_W = 4,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             wr_en,
  input  logic [VAL_W-1:0] wr_val,
  output logic [VAL_W-1:0] rd_pred,
  output logic             rd_hit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [VAL_W-1:0] pred_q [DEPTH];
  logic [VAL_W-1:0] vote_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [VAL_W-1:0] cur_vote, cur_pred, new_pred;

  assign cur_vote = vote_q[idx];
  assign cur_pred = pred_q[idx];
  assign rd_pred  = cur_pred;
  assign rd_hit   = vld_q[idx];

  // majority of three; with no two equal the measurement wins
  always_comb begin
    if (!vld_q[idx])               new_pred = wr_val;
    else if (cur_vote == cur_pred) new_pred = cur_vote;
    else                           new_pred = wr_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      pred_q[idx] <= new_pred;
      vote_q[idx] <= wr_val;
    end
  end

  assert_write_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(idx)]);
  assert_vote_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vote_q[$past(idx)] == $past(wr_val));
  assert_agree_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && vld_q[idx] && cur_vote == cur_pred) |=> pred_q[$past(idx)] == $past(cur_vote));
  assert_outvoted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && vld_q[idx] && cur_vote != cur_pred) |=> pred_q[$past(idx)] == $past(wr_val));
endmodule

// File: rtl/metric_vote_predictor.sv
module metric_vote_predictor #(
  parameter int VAL_W   = 4,
  parameter int ENC_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_valid,
  input  logic [VAL_W-1:0] meas_value,
  output logic [VAL_W-1:0] pred_value,
  output logic             learning
);
  import mvp_pkg::*;
  localparam int IDX_W = 2 * VAL_W;

  logic [HIST_LEN-1:0][VAL_W-1:0] hist;
  logic                           full;
  logic [IDX_W-1:0]               idx;
  logic [VAL_W-1:0]               tab_pred;
  logic                           tab_hit;

  mvp_history #(.VAL_W(VAL_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .push(meas_valid), .value(meas_value),
    .hist(hist), .full(full));

  mvp_index #(.VAL_W(VAL_W), .ENC_SEL(ENC_SEL)) u_idx (
    .hist(hist), .idx(idx));

  mvp_table #(.VAL_W(VAL_W), .IDX_W(IDX_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(meas_valid && full),
    .wr_val(meas_value), .rd_pred(tab_pred), .rd_hit(tab_hit));

  assign learning   = !(full && tab_hit);
  assign pred_value = learning ? hist[0] : tab_pred;

  assert_fallback_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |=> learning ? (pred_value == $past(meas_value)) : 1'b1);
  assert_not_full_learns_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> learning);
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid |=> $stable(pred_value) && $stable(learning));
  assert_hit_uses_table_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && tab_hit) |-> (!learning && pred_value == tab_pred));
endmodule

// File: tb/metric_vote_predictor_tb.sv
module metric_vote_predictor_tb_top;
  localparam int VW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mv = 1'b0;
  logic [VW-1:0] mval = '0;
  logic [VW-1:0] pred_f, pred_r;
  logic learn_f, learn_r;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  metric_vote_predictor #(.VAL_W(VW), .ENC_SEL(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .meas_valid(mv), .meas_value(mval),
    .pred_value(pred_f), .learning(learn_f));
  metric_vote_predictor #(.VAL_W(VW), .ENC_SEL(1)) dut_rle (
    .clk(clk), .rst_n(rst_n), .meas_valid(mv), .meas_value(mval),
    .pred_value(pred_r), .learning(learn_r));

  // behavioural reference, one set per encoding
  int mh   [2][4];
  int mcnt [2];
  int mp   [2][256];
  int mvt  [2][256];
  bit mok  [2][256];

  function automatic int rot(input int x);
    return ((x & 3) << 2) | ((x >> 2) & 3);
  endfunction

  function automatic int idx_of(input int e);
    int run, p;
    if (e == 0) return ((mh[e][1] ^ rot(mh[e][3])) << 4) | (mh[e][0] ^ rot(mh[e][2]));
    run = 1; p = mh[e][0];
    for (int i = 1; i < 4; i++) begin
      if (mh[e][i] == mh[e][0]) run++;
      else begin p = mh[e][i]; break; end
    end
    return (mh[e][0] << 4) | ((((p >> 2) & 3) ^ (p & 3)) << 2) | (run - 1);
  endfunction

  task automatic model_reset();
    for (int e = 0; e < 2; e++) begin
      mcnt[e] = 0;
      for (int i = 0; i < 4; i++) mh[e][i] = 0;
      for (int i = 0; i < 256; i++) mok[e][i] = 0;
    end
  endtask

  task automatic model_push(input int m);
    int k;
    for (int e = 0; e < 2; e++) begin
      if (mcnt[e] == 4) begin
        k = idx_of(e);
        if (!mok[e][k]) mp[e][k] = m;
        else begin
          // majority vote R6: stored vote, stored prediction, measured
          if (mvt[e][k] == mp[e][k]) mp[e][k] = mvt[e][k];
          else if (mvt[e][k] == m || mp[e][k] == m) mp[e][k] = m;
          else mp[e][k] = m;
        end
        mvt[e][k] = m;   // R7
        mok[e][k] = 1;
      end else mcnt[e]++;
      for (int i = 3; i > 0; i--) mh[e][i] = mh[e][i-1];
      mh[e][0] = m;
    end
  endtask

  task automatic compare(input string why);
    int k, ep, el;
    string tag;
    for (int e = 0; e < 2; e++) begin
      if (mcnt[e] < 4) begin ep = mh[e][0]; el = 1; tag = "R2"; end
      else begin
        k = idx_of(e);
        if (!mok[e][k]) begin ep = mh[e][0]; el = 1; tag = "R5"; end
        else begin
          ep = mp[e][k]; el = 0;
          tag = (e == 0) ? "R9 R3 R6 R7" : "R9 R4 R6 R7";
        end
      end
      if (why != "") tag = why;
      n_vec++;
      if (e == 0 ? (pred_f != VW'(ep) || learn_f != el[0])
                 : (pred_r != VW'(ep) || learn_r != el[0])) begin
        n_bad++;
        $display("FAIL %s enc=%0d: pred=%0d learn=%0b expected pred=%0d learn=%0b",
                 tag, e, e == 0 ? pred_f : pred_r, e == 0 ? learn_f : learn_r, ep, el);
      end
    end
  endtask

  // one cycle: check outputs at negedge, then drive the next input
  task automatic step(input bit v, input int m, input string why);
    @(negedge clk);
    compare(why);
    mv = v;
    mval = VW'(m);
    if (v) model_push(m);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, "R1");
    step(0, 0, "R1");
    // filling the history: R2
    step(1, 3, "R2");
    step(1, 7, "");
    step(0, 0, "R8");
    step(1, 12, "");
    step(1, 1, "");
    // periodic pattern: first pass learns (R5), later passes hit (R9)
    for (int r = 0; r < 6; r++)
      for (int i = 0; i < 5; i++) step(1, (i * 3 + 2) % 16, "");
    // noise in a learned period: single outlier is voted down (R6)
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 5; i++) step(1, (r == 1 && i == 2) ? 15 : (i * 3 + 2) % 16, "");
      step(0, 0, "R8");
    end
    // constant runs saturate run length (R4)
    for (int r = 0; r < 12; r++) step(1, 9, "");
    for (int r = 0; r < 12; r++) step(1, (r < 6) ? 4 : 5, "");
    // three-way disagreement on a recurring history: measured wins (R6)
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < 4; i++) step(1, 6, "");
      step(1, r * 2 + 1, "");
    end
    // random stream with idle gaps
    for (int r = 0; r < 600; r++) step(($urandom % 4) != 0, $urandom % 16, "");
    // mid-run reset returns to the initial state (R1)
    @(negedge clk);
    rst_n = 1'b0; mv = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    step(0, 0, "R1");
    step(1, 8, "R1");
    step(0, 0, "R2");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule